// File: doc/BRIEF.md
# EEPROM Write Protection Controller

This block decides, in the same cycle that a write is requested, whether a write to a serial EEPROM may proceed. The memory has a 32 KB main array addressed by 15 bits, a one-time-programmable (OTP) page and an 8-bit configuration register. The bus controller presents a write strobe, a target selector, an address and, for configuration writes, a data byte. The block answers with a combinational grant.

The block owns the configuration register and a sticky flag that records that the OTP page has been consumed. The configuration register holds three things. The first is the polarity of the write-control pin. The second is a lock bit that lets a separate guard pin make the register read-only. The third is a three-bit code that locks a region of the main array starting at address 0, with a size that is a power of two. The OTP flag survives a normal reset and is cleared only by a dedicated manufacturing reset.

Top module: `eeprom_wprot`

## Requirements
- R1: After a normal reset (`rst_n` low at a clock edge) `cfg_q` reads 8'h00. After a manufacturing reset (`mfg_rst_n` low at a clock edge) `otp_used` reads 0.
- R2: With the polarity bit `cfg_q[6]` at 0, a high `wc_pin` denies every main-array and OTP write. A low `wc_pin` lets them through, subject to the other rules.
- R3: With `cfg_q[6]` at 1 the sense of `wc_pin` is inverted: low denies and high allows.
- R4: With the lock bit `cfg_q[7]` at 0, configuration writes ignore `guard_pin`. With `cfg_q[7]` at 1, a configuration write is granted only while `guard_pin` is high.
- R5: The lock code `cfg_q[4:2]` denies main-array writes below a limit. The limits are: 000 none, 001 below 0x0200, 010 below 0x0400, 011 below 0x0800, 100 below 0x1000, 101 below 0x2000, 110 below 0x4000, 111 the whole array.
- R6: A locked main-array address is denied whatever the pins and other bits are. The lock code has no effect on configuration writes, which are still subject to the write-control rule of R2/R3.
- R7: An OTP write is granted at most once. The granted OTP strobe sets `otp_used` at that clock edge, and every later OTP request is denied.
- R8: Bits 5, 1 and 0 of a configuration write are discarded and always read back as 0.
- R9: A normal reset leaves `otp_used` unchanged. Only `mfg_rst_n` clears it.
- R10: `grant` is combinational and is high only while `wr_req` is high. Targets are encoded 00 main array, 01 OTP, 10 configuration and 11 reserved; the reserved target is always denied. State changes only on a clock edge that carries a granted strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the configuration register |
| mfg_rst_n | input | 1 | Synchronous active-low manufacturing reset that clears the OTP flag |
| wc_pin | input | 1 | Write-control pin level |
| guard_pin | input | 1 | Configuration-register guard pin level |
| wr_req | input | 1 | Write strobe |
| wr_tgt | input | 2 | Write target: 00 main, 01 OTP, 10 configuration, 11 reserved |
| wr_addr | input | 15 | Main-array byte address |
| wr_data | input | 8 | Data byte for a configuration write |
| grant | output | 1 | Write allowed in this cycle |
| cfg_q | output | 8 | Current configuration register value |
| otp_used | output | 1 | OTP page has been written |

## Verification
A configuration register holding a wrong value shows up at once on `cfg_q`. It also changes `grant` in the same cycle as the next request: the pin sense flips, a lock boundary moves, or the guard pin is honoured or ignored. A wrong OTP flag shows up on the next OTP request, either as a second grant or as a denial of a fresh page. The sweep therefore programmes each configuration and checks grants on both sides of each lock boundary. Directed sequences then follow the flag across normal and manufacturing resets.

// File: rtl/wprot_pkg.sv
// Shared definitions for the EEPROM write protection controller.
// Assumes an 8-bit configuration register with the bit positions below.
package wprot_pkg;
    typedef enum logic [1:0] {
        TGT_MAIN = 2'b00,
        TGT_OTP  = 2'b01,
        TGT_CFG  = 2'b10,
        TGT_NONE = 2'b11
    } wr_tgt_e;

    localparam int CFG_W      = 8;
    localparam int CFG_LOCK   = 7;  // guard-pin lock bit
    localparam int CFG_POL    = 6;  // write-control polarity bit
    localparam int CFG_CODE_L = 2;  // low bit of the 3-bit region code
    localparam int CODE_W     = 3;
    localparam logic [CFG_W-1:0] CFG_KEEP = 8'hDC;  // writable bits
endpackage

// File: rtl/wprot_cfg_reg.sv
// Configuration register. It loads the masked write data on a granted
// strobe and clears on a synchronous active-low reset. The caller
// decides whether a write is granted.
module wprot_cfg_reg
    import wprot_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CFG_W-1:0] din,
    output logic [CFG_W-1:0] q
);
    // Holds the register; discarded bits are forced to zero on load.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= din & CFG_KEEP;
    end

    // R8: unused bits never read back as 1
    a_r8_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (q & ~CFG_KEEP) == '0);
    // R10: without a load the register keeps its value
    a_r10_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));
endmodule

// File: rtl/wprot_otp_flag.sv
// Sticky flag that marks the OTP page as consumed. It is set by a
// granted OTP write and cleared only by the manufacturing reset.
module wprot_otp_flag (
    input  logic clk,
    input  logic mfg_rst_n,
    input  logic set_en,
    output logic used
);
    // Records the first accepted OTP write.
    always_ff @(posedge clk) begin
        if (!mfg_rst_n)  used <= 1'b0;
        else if (set_en) used <= 1'b1;
    end

    // R9: once set, the flag stays set until a manufacturing reset
    a_r9_sticky: assert property (@(posedge clk) disable iff (!mfg_rst_n)
        used |=> used);
    // R7: a set request always leaves the flag set
    a_r7_set: assert property (@(posedge clk) disable iff (!mfg_rst_n)
        set_en |=> used);
endmodule

// File: rtl/wprot_lock_decode.sv
// Region decoder. A non-zero code k locks the addresses below
// 2**(BASE_LOG2-1+k). A code that reaches ADDR_W locks the whole array.
// Assumes BASE_LOG2-1+7 >= ADDR_W so that the top code covers all.
module wprot_lock_decode #(
    parameter int ADDR_W    = 15,
    parameter int CODE_W    = 3,
    parameter int BASE_LOG2 = 9
) (
    input  logic [CODE_W-1:0] code,
    input  logic [ADDR_W-1:0] addr,
    output logic              locked
);
    localparam int SH_W = $clog2(ADDR_W + (1 << CODE_W) + BASE_LOG2) + 1;

    logic [SH_W-1:0] shift;

    // Address is locked when nothing remains above the region limit.
    always_comb begin
        shift  = SH_W'(BASE_LOG2 - 1) + SH_W'(code);
        locked = (code != '0) && ((addr >> shift) == '0);
    end
endmodule

// File: rtl/eeprom_wprot.sv
// EEPROM write protection controller top. It combines the pin polarity,
// the guard lock, the region lock and the OTP flag into a combinational
// grant. The state elements update only on granted strobes.
module eeprom_wprot
    import wprot_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int BASE_LOG2 = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mfg_rst_n,
    input  logic              wc_pin,
    input  logic              guard_pin,
    input  logic              wr_req,
    input  logic [1:0]        wr_tgt,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CFG_W-1:0]  wr_data,
    output logic              grant,
    output logic [CFG_W-1:0]  cfg_q,
    output logic              otp_used
);
    wr_tgt_e tgt;
    logic    pin_prot;
    logic    region_lock;
    logic    cfg_open;
    logic    cfg_load;
    logic    otp_set;

    assign tgt = wr_tgt_e'(wr_tgt);

    wprot_lock_decode #(
        .ADDR_W(ADDR_W), .CODE_W(CODE_W), .BASE_LOG2(BASE_LOG2)
    ) u_lock (
        .code  (cfg_q[CFG_CODE_L +: CODE_W]),
        .addr  (wr_addr),
        .locked(region_lock)
    );

    // Computes the grant from the target, pins and stored state.
    always_comb begin
        pin_prot = wc_pin ^ cfg_q[CFG_POL];
        cfg_open = !cfg_q[CFG_LOCK] || guard_pin;
        grant    = 1'b0;
        if (wr_req && !pin_prot) begin
            unique case (tgt)
                TGT_MAIN: grant = !region_lock;
                TGT_OTP:  grant = !otp_used;
                TGT_CFG:  grant = cfg_open;
                default:  grant = 1'b0;
            endcase
        end
        cfg_load = grant && (tgt == TGT_CFG);
        otp_set  = grant && (tgt == TGT_OTP);
    end

    wprot_cfg_reg u_cfg (
        .clk (clk),
        .rst_n(rst_n),
        .load(cfg_load),
        .din (wr_data),
        .q   (cfg_q)
    );

    wprot_otp_flag u_otp (
        .clk      (clk),
        .mfg_rst_n(mfg_rst_n),
        .set_en   (otp_set),
        .used     (otp_used)
    );

    // R2 R3: the pin in its protecting level denies everything
    a_r3_pin_denies: assert property (@(posedge clk) disable iff (!rst_n)
        (wc_pin ^ cfg_q[CFG_POL]) |-> !grant);
    // R6: with code 111 no main-array write is granted
    a_r6_full_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_tgt == 2'b00 && cfg_q[4:2] == 3'b111) |-> !grant);
    // R7: a consumed OTP page is never granted again
    a_r7_otp_once: assert property (@(posedge clk) disable iff (!mfg_rst_n)
        (otp_used && wr_tgt == 2'b01) |-> !grant);
    // R4: a locked register with a low guard pin refuses configuration writes
    a_r4_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[7] && !guard_pin && wr_tgt == 2'b10) |-> !grant);
    // R10: no grant without a strobe, and none for the reserved target
    a_r10_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_req || wr_tgt == 2'b11) |-> !grant);
endmodule

// File: tb/eeprom_wprot_tb.sv
module eeprom_wprot_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mfg_rst_n = 1'b0;
    logic        wc_pin = 1'b0;
    logic        guard_pin = 1'b0;
    logic        wr_req = 1'b0;
    logic [1:0]  wr_tgt = 2'b00;
    logic [14:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        grant;
    logic [7:0]  cfg_q;
    logic        otp_used;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    eeprom_wprot u_dut (
        .clk(clk), .rst_n(rst_n), .mfg_rst_n(mfg_rst_n),
        .wc_pin(wc_pin), .guard_pin(guard_pin),
        .wr_req(wr_req), .wr_tgt(wr_tgt), .wr_addr(wr_addr),
        .wr_data(wr_data), .grant(grant), .cfg_q(cfg_q), .otp_used(otp_used)
    );

    // Row: {cfg[7:0], tgt[1:0], addr[14:0], wc, guard, expected grant}
    localparam logic [27:0] VEC [NV] = '{
        {8'h00, 2'b00, 15'h0000, 1'b0, 1'b0, 1'b1},  // R2 low pin allows
        {8'h00, 2'b00, 15'h0000, 1'b1, 1'b0, 1'b0},  // R2 high pin denies
        {8'h40, 2'b00, 15'h0100, 1'b0, 1'b0, 1'b0},  // R3 inverted low denies
        {8'h40, 2'b00, 15'h0100, 1'b1, 1'b0, 1'b1},  // R3 inverted high allows
        {8'h04, 2'b00, 15'h01FF, 1'b0, 1'b0, 1'b0},  // R5 512 B edge inside
        {8'h04, 2'b00, 15'h0200, 1'b0, 1'b0, 1'b1},  // R5 512 B edge outside
        {8'h08, 2'b00, 15'h03FF, 1'b0, 1'b0, 1'b0},  // R5 1 KB inside
        {8'h0C, 2'b00, 15'h0800, 1'b0, 1'b0, 1'b1},  // R5 2 KB outside
        {8'h10, 2'b00, 15'h0FFF, 1'b0, 1'b0, 1'b0},  // R5 4 KB inside
        {8'h14, 2'b00, 15'h2000, 1'b0, 1'b0, 1'b1},  // R5 8 KB outside
        {8'h18, 2'b00, 15'h3FFF, 1'b0, 1'b0, 1'b0},  // R5 16 KB inside
        {8'h18, 2'b00, 15'h4000, 1'b0, 1'b0, 1'b1},  // R5 16 KB outside
        {8'h1C, 2'b00, 15'h7FFF, 1'b0, 1'b0, 1'b0},  // R6 whole array locked
        {8'h1C, 2'b10, 15'h0000, 1'b0, 1'b0, 1'b1},  // R6 lock ignores cfg target
        {8'h80, 2'b10, 15'h0000, 1'b0, 1'b0, 1'b0},  // R4 guard low blocks
        {8'h80, 2'b10, 15'h0000, 1'b0, 1'b1, 1'b1},  // R4 guard high opens
        {8'h00, 2'b10, 15'h0000, 1'b0, 1'b0, 1'b1},  // R4 guard ignored
        {8'h40, 2'b10, 15'h0000, 1'b0, 1'b1, 1'b0},  // R6 pin still guards cfg
        {8'h00, 2'b01, 15'h0000, 1'b1, 1'b0, 1'b0},  // R2 pin guards OTP
        {8'h00, 2'b11, 15'h0000, 1'b0, 1'b1, 1'b0}   // R10 reserved target
    };
    string VEC_REQ [NV] = '{"R2", "R2", "R3", "R3", "R5", "R5", "R5", "R5",
                            "R5", "R5", "R5", "R5", "R6", "R6", "R4", "R4",
                            "R4", "R6", "R2", "R10"};

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reset_cfg();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Granted strobe across one rising edge; inputs change at negedges.
    task automatic strobe(input logic [1:0] t, input logic [7:0] d, input logic wc);
        @(negedge clk);
        wr_tgt = t; wr_data = d; wc_pin = wc; wr_req = 1'b1;
        @(negedge clk);
        wr_req = 1'b0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        repeat (2) @(negedge clk);
        mfg_rst_n = 1'b1;
        rst_n = 1'b1;
        #1;
        chk("R1", cfg_q, 8'h00);
        chk("R1", {7'b0, otp_used}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            reset_cfg();
            strobe(2'b10, VEC[i][27:20], 1'b0);
            guard_pin = VEC[i][1];
            wc_pin    = VEC[i][2];
            wr_addr   = VEC[i][17:3];
            wr_tgt    = VEC[i][19:18];
            wr_req    = 1'b1;
            #1;
            chk(VEC_REQ[i], {7'b0, grant}, {7'b0, VEC[i][0]});
            wr_req = 1'b0;
            #1;
            chk("R10", {7'b0, grant}, 8'h00);
        end

        // R8: discarded bits read back as 0
        reset_cfg();
        strobe(2'b10, 8'hFF, 1'b0);
        chk("R8", cfg_q, 8'hDC);
        // R1: a normal reset clears the register
        reset_cfg();
        chk("R1", cfg_q, 8'h00);

        // R4 R10: a denied configuration write leaves the register alone
        strobe(2'b10, 8'h80, 1'b0);
        guard_pin = 1'b0;
        strobe(2'b10, 8'h04, 1'b0);
        chk("R4", cfg_q, 8'h80);
        guard_pin = 1'b1;
        strobe(2'b10, 8'h04, 1'b0);
        chk("R4", cfg_q, 8'h04);

        // R7: OTP granted once, then denied
        reset_cfg();
        @(negedge clk);
        wr_tgt = 2'b01; wc_pin = 1'b0; wr_req = 1'b1;
        #1;
        chk("R7", {7'b0, grant}, 8'h01);
        @(negedge clk);
        #1;
        chk("R7", {7'b0, otp_used}, 8'h01);
        chk("R7", {7'b0, grant}, 8'h00);
        wr_req = 1'b0;

        // R9: a normal reset keeps the flag; a manufacturing reset clears it
        reset_cfg();
        chk("R9", {7'b0, otp_used}, 8'h01);
        wr_tgt = 2'b01; wr_req = 1'b1;
        #1;
        chk("R9", {7'b0, grant}, 8'h00);
        wr_req = 1'b0;
        @(negedge clk);
        mfg_rst_n = 1'b0;
        @(negedge clk);
        mfg_rst_n = 1'b1;
        chk("R1", {7'b0, otp_used}, 8'h00);
        wr_req = 1'b1;
        #1;
        chk("R9", {7'b0, grant}, 8'h01);
        wr_req = 1'b0;

        // R10: main-array grants leave configuration and flag unchanged
        strobe(2'b00, 8'hFF, 1'b0);
        chk("R10", cfg_q, 8'h00);
        chk("R10", {7'b0, otp_used}, 8'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule